// File: doc/BRIEF.md
# Dual Timebase Reference Selector

This block decides which of two redundant timebase sources, A or B, drives the downstream reference. Each source has a raw health input. The block qualifies that input over a programmable number of cycles before the source counts as usable. A usable source loses that standing at once when its health input drops. When the active source becomes unusable and the other one is usable, the block switches away from it. When B is active and A is usable again, the block returns to A as the preferred source, but only after a holdoff window has expired.

A two-bit policy input sets how each switch is made:

- **Hitless:** the block waits for an external phase-aligned indication before it commits.
- **Bounded step:** the block commits only when the measured offset between the sources is within a programmable limit.
- **Cutover:** the block commits at once and raises an alarm.

Every committed switch produces a one-cycle event and updates the selection. It also records the magnitude of the offset between the two sources in that cycle, so a later review can judge how far time trust was disturbed. The analog clock multiplexer and the alignment hardware are outside this block. The block only sees a signed offset word and an aligned flag.

Top module: `ref_selector`

## Requirements
- R1: After synchronous reset the selection is A (`sel_o`=0), `switch_o` is 0, `step_o` is 0 and all four `alarm_o` bits are 0.
- R2: A source becomes usable at the (N+1)-th consecutive rising edge at which its health input is high, where N is `qual_len_i`. It becomes unusable in the same cycle its health input goes low.
- R3: When the active source is unusable and the other source is usable, the block switches regardless of the holdoff window.
- R4: When B is active and usable, A is usable, and the holdoff window has expired, the block switches back to A.
- R5: A commit loads a holdoff counter with `holdoff_len_i`. The counter decrements once per cycle, and a return to A is only taken at an edge where the counter is already zero. With a length of H, the return comes H+1 cycles after the previous switch at the earliest.
- R6: Every committed switch raises `switch_o` for one cycle. In that same cycle `sel_o` shows the new source (0=A, 1=B), and `step_o` holds the absolute value of the two's-complement `phase_off_i` sampled at the commit edge. `step_o` keeps that value until the next switch.
- R7: In hitless policy (`mode_i`=0) a switch is committed only at an edge where `aligned_i` is high.
- R8: In hitless policy, if `aligned_i` is not seen, the switch is forced at the (T+1)-th edge after the wait began, where T is `align_tmo_i`. A forced switch raises `alarm_o[1]` (cutover) and `alarm_o[3]` (alignment timeout) in the event cycle.
- R9: In bounded-step policy (`mode_i`=1) a switch with |offset| ≤ `max_step_i` commits without alarm. A larger offset is refused: the selection is unchanged and `alarm_o[2]` stays high in each cycle the refusal persists.
- R10: In cutover policy (`mode_i`=2 or 3) a switch commits at the first edge the request is seen, and `alarm_o[1]` is high in the event cycle.
- R11: While neither source is usable, the selection is kept, no switch occurs, and `alarm_o[0]` is high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| health_a | input | 1 | Raw health of source A |
| health_b | input | 1 | Raw health of source B |
| mode_i | input | 2 | Switch policy: 0 hitless, 1 bounded step, 2/3 cutover |
| phase_off_i | input | PW | Two's-complement offset between B and A |
| aligned_i | input | 1 | Phase-aligned indication from alignment hardware |
| max_step_i | input | PW | Largest offset magnitude allowed in bounded-step policy |
| qual_len_i | input | CW | Health qualification length N |
| holdoff_len_i | input | HW | Holdoff window length H after a switch |
| align_tmo_i | input | TW | Alignment wait limit T for hitless policy |
| sel_o | output | 1 | Selected source, 0=A, 1=B |
| switch_o | output | 1 | One-cycle switch event |
| step_o | output | PW | Offset magnitude recorded at the last switch |
| alarm_o | output | 4 | [0] both unusable, [1] cutover, [2] step refused, [3] alignment timeout |

## Verification
Two functions can land in the same cycle: the qualification of the standby source, and the immediate loss of the active one. The bench provokes this by raising one health input and dropping the other on the same falling edge. It then expects the both-unusable alarm for exactly the qualification interval, followed by a switch at the edge on which the standby source qualifies. The same overlap is repeated under each policy, so the policy decision (refuse, wait or force) is judged at that exact edge. The bench also lets the holdoff expiry meet an already qualified A, and checks that the return happens on the first edge after expiry and not earlier.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int NSRC = 2;

    typedef enum logic [1:0] {
        MODE_HITLESS     = 2'd0,
        MODE_BOUNDED     = 2'd1,
        MODE_CUTOVER     = 2'd2,
        MODE_CUTOVER_ALT = 2'd3
    } mode_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sel_state_e;

    typedef struct packed {
        logic align_tmo;
        logic step_refused;
        logic cutover;
        logic both_bad;
    } alarm_t;

    function automatic logic is_cut(mode_e m);
        return (m == MODE_CUTOVER) || (m == MODE_CUTOVER_ALT);
    endfunction

endpackage

// File: rtl/refsel_qualify.sv
module refsel_qualify #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          health_i,
    input  logic [CW-1:0] len_i,
    output logic          qual_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!health_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign qual_o = health_i && (cnt_q >= len_i);

    AST_QUAL_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (qual_o && len_i != '0) |-> $past(health_i)); // R2

endmodule

// File: rtl/refsel_holdoff.sv
module refsel_holdoff #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [HW-1:0] len_i,
    output logic          idle_o
);
    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HW'(1);
        end
    end

    assign idle_o = (cnt_q == '0);

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(len_i))); // R5

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int PW = 16,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          qual_a_i,
    input  logic          qual_b_i,
    input  logic          hold_idle_i,
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] phase_off_i,
    input  logic          aligned_i,
    input  logic [PW-1:0] max_step_i,
    input  logic [TW-1:0] align_tmo_i,
    output logic          commit_o,
    output logic          sel_o,
    output logic          evt_o,
    output logic [PW-1:0] step_o,
    output alarm_t        alarm_o
);
    mode_e         mode;
    sel_state_e    state_q, state_d;
    logic [TW-1:0] wcnt_q, wcnt_d;
    src_e          sel_q;
    logic          evt_q;
    logic [PW-1:0] step_q;
    alarm_t        alarm_q;

    logic          cur_ok, oth_ok, fail_req, rev_req, req;
    logic [PW-1:0] mag;
    logic          commit, cut, tmo, refuse;

    assign mode = mode_e'(mode_i);

    always_comb begin
        cur_ok   = (sel_q == SRC_B) ? qual_b_i : qual_a_i;
        oth_ok   = (sel_q == SRC_B) ? qual_a_i : qual_b_i;
        fail_req = !cur_ok && oth_ok;
        rev_req  = (sel_q == SRC_B) && cur_ok && qual_a_i && hold_idle_i;
        req      = fail_req || rev_req;
        mag      = phase_off_i[PW-1] ? (~phase_off_i + PW'(1)) : phase_off_i;

        commit  = 1'b0;
        cut     = 1'b0;
        tmo     = 1'b0;
        refuse  = 1'b0;
        state_d = state_q;
        wcnt_d  = wcnt_q;

        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (is_cut(mode)) begin
                        commit = 1'b1;
                        cut    = 1'b1;
                    end else if (mode == MODE_BOUNDED) begin
                        if (mag <= max_step_i) commit = 1'b1;
                        else                   refuse = 1'b1;
                    end else if (aligned_i) begin
                        commit = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                        wcnt_d  = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!req || mode != MODE_HITLESS) begin
                    state_d = ST_IDLE;
                end else if (aligned_i) begin
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end else if (wcnt_q == align_tmo_i) begin
                    commit  = 1'b1;
                    cut     = 1'b1;
                    tmo     = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    wcnt_d = wcnt_q + TW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            sel_q   <= SRC_A;
            evt_q   <= 1'b0;
            step_q  <= '0;
            alarm_q <= '0;
        end else begin
            state_q              <= state_d;
            wcnt_q               <= wcnt_d;
            evt_q                <= commit;
            alarm_q.cutover      <= cut;
            alarm_q.align_tmo    <= tmo;
            alarm_q.step_refused <= refuse;
            alarm_q.both_bad     <= !qual_a_i && !qual_b_i;
            if (commit) begin
                sel_q  <= (sel_q == SRC_A) ? SRC_B : SRC_A;
                step_q <= mag;
            end
        end
    end

    assign commit_o = commit;
    assign sel_o    = sel_q;
    assign evt_o    = evt_q;
    assign step_o   = step_q;
    assign alarm_o  = alarm_q;

    AST_SEL_WITH_EVT: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> evt_q); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (evt_q && $past(mode_i) == MODE_BOUNDED) |-> (step_q <= $past(max_step_i))); // R9

    AST_HITLESS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (evt_q && $past(mode_i) == MODE_HITLESS && !alarm_q.cutover) |-> $past(aligned_i)); // R7

    AST_CUT_ALARM: assert property (@(posedge clk) disable iff (rst)
        (evt_q && is_cut(mode_e'($past(mode_i)))) |-> alarm_q.cutover); // R10

    AST_REVERT_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (evt_q && $past(sel_q) == SRC_B && $past(qual_b_i)) |-> $past(hold_idle_i)); // R5

    AST_BOTH_BAD_NO_EVT: assert property (@(posedge clk) disable iff (rst)
        alarm_q.both_bad |-> !evt_q); // R11

endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import refsel_pkg::*;
#(
    parameter int PW = 16,
    parameter int CW = 8,
    parameter int HW = 16,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          health_a,
    input  logic          health_b,
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] phase_off_i,
    input  logic          aligned_i,
    input  logic [PW-1:0] max_step_i,
    input  logic [CW-1:0] qual_len_i,
    input  logic [HW-1:0] holdoff_len_i,
    input  logic [TW-1:0] align_tmo_i,
    output logic          sel_o,
    output logic          switch_o,
    output logic [PW-1:0] step_o,
    output logic [3:0]    alarm_o
);
    logic [NSRC-1:0] health_v;
    logic [NSRC-1:0] qual_v;
    logic            commit;
    logic            hold_idle;
    alarm_t          alarm;

    assign health_v = {health_b, health_a};

    for (genvar i = 0; i < NSRC; i++) begin : g_qual
        refsel_qualify #(.CW(CW)) u_qual (
            .clk      (clk),
            .rst      (rst),
            .health_i (health_v[i]),
            .len_i    (qual_len_i),
            .qual_o   (qual_v[i])
        );
    end

    refsel_holdoff #(.HW(HW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (commit),
        .len_i  (holdoff_len_i),
        .idle_o (hold_idle)
    );

    refsel_fsm #(.PW(PW), .TW(TW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .qual_a_i    (qual_v[0]),
        .qual_b_i    (qual_v[1]),
        .hold_idle_i (hold_idle),
        .mode_i      (mode_i),
        .phase_off_i (phase_off_i),
        .aligned_i   (aligned_i),
        .max_step_i  (max_step_i),
        .align_tmo_i (align_tmo_i),
        .commit_o    (commit),
        .sel_o       (sel_o),
        .evt_o       (switch_o),
        .step_o      (step_o),
        .alarm_o     (alarm)
    );

    assign alarm_o = alarm;

endmodule

// File: tb/sim_ref_selector.sv
`timescale 1ns/1ps
module sim_ref_selector;
    localparam int PW = 16;
    localparam int CW = 8;
    localparam int HW = 16;
    localparam int TW = 12;

    typedef struct {
        bit       sel;
        int       step;
        bit       cut;
        bit       tmo;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          health_a, health_b;
    logic [1:0]    mode;
    logic [PW-1:0] phase;
    logic          aligned;
    logic [PW-1:0] max_step;
    logic [CW-1:0] qual_len;
    logic [HW-1:0] holdoff;
    logic [TW-1:0] tmo_len;
    logic          sel_o, switch_o;
    logic [PW-1:0] step_o;
    logic [3:0]    alarm_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    ref_selector #(.PW(PW), .CW(CW), .HW(HW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .health_a(health_a), .health_b(health_b),
        .mode_i(mode), .phase_off_i(phase), .aligned_i(aligned),
        .max_step_i(max_step), .qual_len_i(qual_len), .holdoff_len_i(holdoff),
        .align_tmo_i(tmo_len), .sel_o(sel_o), .switch_o(switch_o),
        .step_o(step_o), .alarm_o(alarm_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input bit s, input int st, input bit c, input bit t);
        exp_t e;
        e.sel = s; e.step = st; e.cut = c; e.tmo = t;
        exp_q.push_back(e);
    endtask

    // monitor: every switch event is matched against the scoreboard (R6, R10, R8)
    always @(negedge clk) begin
        if (!rst && switch_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected switch event", int'(sel_o), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(sel_o == e.sel, "R6 event sel", int'(sel_o), int'(e.sel));
                check(int'(step_o) == e.step, "R6 event step", int'(step_o), e.step);
                check(alarm_o[1] == e.cut, "R10 event cutover alarm", int'(alarm_o[1]), int'(e.cut));
                check(alarm_o[3] == e.tmo, "R8 event timeout alarm", int'(alarm_o[3]), int'(e.tmo));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; health_a = 1'b1; health_b = 1'b1; mode = 2'd2;
        phase = '0; aligned = 1'b0; max_step = 16'd100; qual_len = 8'd2;
        holdoff = 16'd10; tmo_len = 12'd5;
        tick(3);
        rst = 1'b0;
        check(sel_o == 1'b0, "R1 sel after reset", int'(sel_o), 0);
        check(switch_o == 1'b0, "R1 switch after reset", int'(switch_o), 0);
        check(alarm_o == 4'd0, "R1 alarms after reset", int'(alarm_o), 0);
        check(step_o == '0, "R1 step after reset", int'(step_o), 0);
        tick(6);
        check(alarm_o[0] == 1'b0, "R11 both-bad clear when healthy", int'(alarm_o[0]), 0);

        // failover in cutover policy (R3, R10)
        phase = -16'd37; health_a = 1'b0; push(1'b1, 37, 1'b1, 1'b0);
        tick(1);
        check(sel_o == 1'b1, "R3 failover to B", int'(sel_o), 1);
        check(alarm_o[1] == 1'b1, "R10 cutover alarm", int'(alarm_o[1]), 1);
        health_a = 1'b1; phase = 16'd20;
        tick(1);
        check(switch_o == 1'b0, "R6 event lasts one cycle", int'(switch_o), 0);
        check(alarm_o[1] == 1'b0, "R10 cutover alarm pulse", int'(alarm_o[1]), 0);
        tick(9);
        check(sel_o == 1'b1, "R5 holdoff blocks revert", int'(sel_o), 1);
        push(1'b0, 20, 1'b1, 1'b0);
        tick(1);
        check(sel_o == 1'b0, "R4 revert after holdoff", int'(sel_o), 0);

        // both unusable, then qualification timing (R11, R2)
        health_b = 1'b0;
        tick(3);
        health_a = 1'b0;
        tick(2);
        check(alarm_o[0] == 1'b1, "R11 both-bad alarm", int'(alarm_o[0]), 1);
        check(sel_o == 1'b0, "R11 selection kept", int'(sel_o), 0);
        health_b = 1'b1; phase = 16'd5; push(1'b1, 5, 1'b1, 1'b0);
        tick(2);
        check(sel_o == 1'b0, "R2 not yet qualified", int'(sel_o), 0);
        check(alarm_o[0] == 1'b1, "R11 both-bad during qualification", int'(alarm_o[0]), 1);
        tick(1);
        check(sel_o == 1'b1, "R2 switch on qualification", int'(sel_o), 1);
        check(alarm_o[0] == 1'b0, "R11 both-bad clears", int'(alarm_o[0]), 0);

        // bounded step policy (R9)
        mode = 2'd1; phase = 16'd250; health_a = 1'b1; health_b = 1'b0;
        tick(3);
        check(alarm_o[2] == 1'b1, "R9 oversize step refused", int'(alarm_o[2]), 1);
        check(sel_o == 1'b1, "R9 selection unchanged", int'(sel_o), 1);
        tick(1);
        check(alarm_o[2] == 1'b1, "R9 refusal persists", int'(alarm_o[2]), 1);
        tick(1);
        phase = -16'd80; push(1'b0, 80, 1'b0, 1'b0);
        tick(1);
        check(sel_o == 1'b0, "R9 in-bound step commits", int'(sel_o), 0);
        check(alarm_o[2] == 1'b0, "R9 refusal cleared", int'(alarm_o[2]), 0);

        // hitless policy with alignment (R7)
        mode = 2'd0; aligned = 1'b0; phase = 16'd3; health_b = 1'b1; health_a = 1'b0;
        push(1'b1, 3, 1'b0, 1'b0);
        tick(5);
        check(sel_o == 1'b0, "R7 waits for alignment", int'(sel_o), 0);
        aligned = 1'b1;
        tick(1);
        check(sel_o == 1'b1, "R7 commits when aligned", int'(sel_o), 1);
        aligned = 1'b0;

        // hitless policy timeout (R8)
        phase = -16'd9; health_a = 1'b1; health_b = 1'b0; push(1'b0, 9, 1'b1, 1'b1);
        tick(8);
        check(sel_o == 1'b1, "R8 before timeout", int'(sel_o), 1);
        tick(1);
        check(sel_o == 1'b0, "R8 forced at timeout", int'(sel_o), 0);
        check(alarm_o[3] == 1'b1, "R8 timeout alarm", int'(alarm_o[3]), 1);

        tick(3);
        check(exp_q.size() == 0, "R6 all expected switches seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule